// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Edge Interrupts

A bank of general-purpose pins that software controls through four word registers. Each pin can be an input or an output. Reading the data register returns the pin levels after synchronization. Writing the data register loads the output latch. A pin set as an output drives its latch value. Its sampled level is taken from that latch, so a read of the data register returns what the pin drives.

Every pin has its own interrupt line. When the interrupt of a pin is enabled, the line pulses for one clock on the selected edge of the pin's sampled level. Edge detection uses the sampled level for outputs too. Software can therefore raise the interrupt of an output pin by toggling its latch, which makes a software test path for the interrupt controller. Register bits above the number of pins read as zero and ignore writes.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every pin is an input (`pin_oe_o` all zero), the output latch is zero, all edge selects and enables are zero, and `irq_o` is zero.
- R2: Register indices 1 (direction, 1 = output), 2 (edge select) and 3 (interrupt enable) are written when `req_i && we_i`. A read (`req_i && !we_i`) of any of them returns the stored value on `rdata_o` one clock later.
- R3: A read of index 0 (data) returns, for each input pin, the level of `pin_i` after a two-flop synchronizer. A pin change shows up in a read two clocks after the first edge that samples it.
- R4: A write to index 0 loads the output latch. `pin_o` always equals the latch, `pin_oe_o` always equals the direction register, and `pin_o` changes only on a data write.
- R5: For an output pin, the sampled level, and so the data read, follows the latch and ignores `pin_i`.
- R6: Edge select bit 1 means rising and 0 means falling. On the selected edge of the sampled level, the pin's `irq_o` bit is high for exactly one clock, two clocks after the edge that first samples the change.
- R7: A pin whose enable bit is 0 never raises its interrupt bit.
- R8: For an output pin with its interrupt enabled, a software write that toggles its latch in the selected direction pulses that pin's interrupt.
- R9: Bits at and above `NUM_PINS` (bits 12 to 15 by default) read as zero in every register and have no effect when written.
- R10: A pin held at a fixed level raises no interrupt. This holds after reset release and while enables or edge selects are changed.
- R11: Each pin drives only its own `irq_o` bit. A change on one pin pulses no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register index: 0 data, 1 direction, 2 edge select, 3 enable |
| wdata_i | input | REG_W (16) | Write data |
| rdata_o | output | REG_W (16) | Read data, registered |
| pin_i | input | NUM_PINS (12) | Pad input levels |
| pin_o | output | NUM_PINS (12) | Output latch to the pads |
| pin_oe_o | output | NUM_PINS (12) | Pad output enables |
| irq_o | output | NUM_PINS (12) | One interrupt pulse line per pin |

## Verification
The assertions assume that `addr_i`, `we_i` and `wdata_i` are known whenever `req_i` is high. They also assume that `pin_i` is held through reset, so that the synchronizer flops start from clean values. The bench drives every input only at the falling clock edge. It changes `pin_i` one bit at a time or as a whole constant word, and it waits out the full synchronizer and edge latency before it starts the next stimulus. As a result, each observed interrupt pulse can be traced to exactly one change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_IDX_W = 2;
  typedef enum logic [REG_IDX_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_EDGE = 2'd2,
    REG_IEN  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned WIDTH   = 12,
  parameter int unsigned ARM_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] rise_sel_i,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] irq_o
);
  localparam int unsigned ARM_W = $clog2(ARM_CYC + 1);

  logic [WIDTH-1:0] prev_q;
  logic [ARM_W-1:0] arm_cnt_q;
  logic             armed;

  // hold off edges until prev_q holds a real sample (no pulse at reset release)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_cnt_q <= '0;
    else if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
  end
  assign armed = (arm_cnt_q == ARM_W'(ARM_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise, fall;
    assign rise     = lvl_i[i] & ~prev_q[i];
    assign fall     = ~lvl_i[i] & prev_q[i];
    assign irq_o[i] = armed & en_i[i] & (rise_sel_i[i] ? rise : fall);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 12,
  parameter int unsigned REG_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]  lvl_i,
  output logic [NUM_PINS-1:0]  latch_o,
  output logic [NUM_PINS-1:0]  dir_o,
  output logic [NUM_PINS-1:0]  rise_o,
  output logic [NUM_PINS-1:0]  en_o
);
  logic [NUM_PINS-1:0] wval, rsel;
  logic [REG_W-1:0]    rdata_q;
  reg_idx_e            idx;

  assign idx  = reg_idx_e'(addr_i);
  assign wval = wdata_i[NUM_PINS-1:0];

  if (REG_W > NUM_PINS) begin : g_pad
    logic wdata_unused;
    assign wdata_unused = ^wdata_i[REG_W-1:NUM_PINS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      rise_o  <= '0;
      en_o    <= '0;
    end else if (req_i && we_i) begin
      case (idx)
        REG_DATA: latch_o <= wval;
        REG_DIR:  dir_o   <= wval;
        REG_EDGE: rise_o  <= wval;
        REG_IEN:  en_o    <= wval;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      REG_DATA: rsel = lvl_i;
      REG_DIR:  rsel = dir_o;
      REG_EDGE: rsel = rise_o;
      REG_IEN:  rsel = en_o;
      default:  rsel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= REG_W'(rsel);
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 12,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]  pin_i,
  output logic [NUM_PINS-1:0]  pin_o,
  output logic [NUM_PINS-1:0]  pin_oe_o,
  output logic [NUM_PINS-1:0]  irq_o
);
  localparam int unsigned ARM_CYC = SYNC_STAGES + 1;

  logic [NUM_PINS-1:0] latch_w, dir_w, rise_w, en_w, pad_w, lvl_w;

  // outputs sample their own latch, inputs sample the pad
  assign pad_w = (dir_w & latch_w) | (~dir_w & pin_i);

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_w), .q_o(lvl_w)
  );

  gpio_edge_det #(.WIDTH(NUM_PINS), .ARM_CYC(ARM_CYC)) u_edge (
    .clk_i, .rst_ni, .lvl_i(lvl_w), .rise_sel_i(rise_w), .en_i(en_w), .irq_o
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .lvl_i(lvl_w), .latch_o(latch_w), .dir_o(dir_w), .rise_o(rise_w), .en_o(en_w)
  );

  assign pin_o    = latch_w;
  assign pin_oe_o = dir_w;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int unsigned NUM_PINS = 12,
  parameter int unsigned REG_W    = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [1:0]          addr_i,
  input logic [REG_W-1:0]    rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] irq_o,
  input logic [NUM_PINS-1:0] lvl_w,
  input logic [NUM_PINS-1:0] en_w
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (pin_oe_o == '0 && pin_o == '0 && irq_o == '0);
    end
  end

  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == 2'd0) |=> $stable(pin_o));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |=> ((irq_o & $past(irq_o)) == '0));

  assert_enable_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~en_w) == '0);

  assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o >> NUM_PINS) == '0);

  assert_needs_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~(lvl_w ^ $past(lvl_w))) == '0);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .rdata_o, .pin_o, .pin_oe_o, .irq_o,
  .lvl_w, .en_w
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NP = 12;
  localparam int unsigned RW = 16;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [RW-1:0] wdata_i = '0;
  logic [RW-1:0] rdata_o;
  logic [NP-1:0] pin_i = '0, pin_o, pin_oe_o, irq_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_bank u_dut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .irq_o
  );

  task automatic chk(input string rq, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk);
    req_i = 0;
    d = rdata_o;
  endtask

  // observe irq over a window; every expected bit must pulse exactly once
  task automatic watch(input string rq, input logic [NP-1:0] exp);
    logic [NP-1:0] seen, twice;
    seen = '0; twice = '0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      twice |= seen & irq_o;
      seen  |= irq_o;
    end
    chk(rq, RW'(seen), RW'(exp));
    chk({rq, " single"}, RW'(twice), '0);
  endtask

  initial begin
    logic [RW-1:0] d;
    logic [RW-1:0] pats [4];
    pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5C3; pats[3] = 16'h5A3C;
    pin_i = 12'hA5A;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 oe", RW'(pin_oe_o), '0);
    chk("R1 out", RW'(pin_o), '0);
    chk("R1 irq", RW'(irq_o), '0);
    for (int a = 1; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reg", d, '0);
    end
    // R10 pins held since reset: no pulse when interrupts enabled both ways
    wr(2'd3, 16'hFFFF);
    watch("R10 hold rising", '0);
    wr(2'd2, 16'hFFFF);
    watch("R10 edge change", '0);
    wr(2'd2, 16'h0000);
    watch("R10 edge change back", '0);
    // R3 data read of inputs
    rd(2'd0, d); chk("R3 read", d, 16'h0A5A);
    pin_i = 12'h3C6;
    @(negedge clk); @(negedge clk);
    rd(2'd0, d); chk("R3 read2", d, 16'h03C6);
    wr(2'd3, 16'h0000);
    pin_i = '0;
    repeat (4) @(negedge clk);
    // R2 / R9 register sweep
    for (int a = 1; a < 4; a++)
      for (int k = 0; k < 4; k++) begin
        wr(2'(a), pats[k]);
        rd(2'(a), d);
        chk("R2 R9 readback", d, pats[k] & 16'h0FFF);
      end
    wr(2'd1, '0); wr(2'd2, '0); wr(2'd3, '0);
    wr(2'd0, 16'hF000);
    chk("R9 data write upper", RW'(pin_o), '0);
    wr(2'd0, 16'hFFFF);
    chk("R4 latch", RW'(pin_o), 16'h0FFF);
    wr(2'd0, '0);
    // R6 R7 R11 input edge sweep
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++) begin
          logic [NP-1:0] bitp;
          bitp = NP'(1) << p;
          wr(2'd2, s ? 16'hFFFF : 16'h0000);
          wr(2'd3, RW'(e ? ALL : ~bitp));
          pin_i = bitp;
          watch("R6 R7 R11 rise", (e && s) ? bitp : '0);
          pin_i = '0;
          watch("R6 R7 R11 fall", (e && !s) ? bitp : '0);
        end
    // R4 R5 R8 output pins with the pads driven opposite
    wr(2'd1, RW'(ALL));
    chk("R4 oe", RW'(pin_oe_o), 16'h0FFF);
    wr(2'd3, RW'(ALL));
    for (int p = 0; p < NP; p++) begin
      logic [NP-1:0] bitp;
      bitp = NP'(1) << p;
      pin_i = ~bitp;
      wr(2'd2, 16'hFFFF);
      wr(2'd0, RW'(bitp));
      chk("R4 pin_o", RW'(pin_o), RW'(bitp));
      watch("R8 rise", bitp);
      rd(2'd0, d); chk("R5 readback", d, RW'(bitp));
      wr(2'd0, '0);
      watch("R8 fall ignored", '0);
      wr(2'd2, '0);
      wr(2'd0, RW'(bitp));
      watch("R8 rise ignored", '0);
      wr(2'd0, '0);
      watch("R8 fall", bitp);
    end
    // R3 R5 mixed direction
    wr(2'd3, '0);
    wr(2'd1, 16'h00F0);
    wr(2'd0, 16'h0FA0);
    pin_i = 12'h50F;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk("R3 R5 mixed", d, 16'h05AF);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule